// File: doc/BRIEF.md
# Dual-Port Address Contention Arbiter

This block sits beside a two-port shared RAM. It watches the two access ports and finds the cycles in which both are enabled on the same word. It lets one port through and drives an active-low busy toward the other. It also produces a per-port write qualifier that the RAM uses to gate its write strobes, and a per-port flag for reads whose data cannot be trusted.

A port that was already on the location keeps the grant. When both ports arrive in the same cycle, the left port wins. The decision is combinational on the current inputs and one cycle of per-port history, so busy and the qualifiers change in the same cycle as the address or enable that causes the collision. The grant state machine has three states:
- `GR_FREE`: no collision.
- `GR_LEFT`: the left port owns the word and the right port is busy.
- `GR_RIGHT`: the right port owns the word and the left port is busy.

Its transitions are:
- *collide*: FREE to LEFT or FREE to RIGHT, when a match appears.
- *keep*: the owner stays while it holds.
- *handover*: LEFT to RIGHT or RIGHT to LEFT, when the owner moves but the ports still match.
- *release*: any state back to FREE, when the match disappears.

Several devices can be combined for wider words. In that case one device is the master and arbitrates. The others are slaves: they take busy from the master through a one-flop sampling stage and do not arbitrate themselves.

Top module: `dpc_arbiter`

## Requirements
- R1: In master mode (`master_mode`=1) both `l_busy_n` and `r_busy_n` are 1 unless `l_ce` and `r_ce` are both 1 and `l_addr` equals `r_addr`.
- R2: In master mode, when both ports start an access to the same address in the same cycle (neither was enabled on that address in the previous cycle), `r_busy_n` is 0 and `l_busy_n` is 1 in that cycle. On a match, exactly one busy is 0.
- R3: In master mode, if one port was enabled on an address in the previous cycle and the other port newly arrives on that address, the newcomer's busy is 0. This holds for either port as the newcomer.
- R4: The owner keeps the grant while its enable stays 1 and its address is unchanged. When its enable drops or its address changes, the grant is re-decided in that same cycle.
- R5: In master mode, `x_wr_ok` = `x_ce` & `x_we` & `x_busy_n`, for x = l and r.
- R6: `x_rd_unsure` is 1 exactly when `x_ce` is 1, `x_we` is 0 and the port's busy is active. Reads are never blocked.
- R7: In slave mode (`master_mode`=0), `l_busy_n` and `r_busy_n` are held at 1 regardless of addresses. Each `x_busy_in_n` is registered once. A sampled 0 makes `x_wr_ok` 0 from the cycle after the edge that captured it, and makes `x_rd_unsure` follow it in the same way.
- R8: In slave mode, after a port's sampled busy input returns from 0 to 1, that port's `x_wr_ok` stays 0 for one further cycle. After that it is `x_ce` & `x_we`.
- R9: During and after reset, with both enables low, both busy outputs are 1 and both qualifiers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| master_mode | input | 1 | 1 = arbitrate and drive busy, 0 = follow external busy |
| l_ce | input | 1 | Left port enable |
| l_we | input | 1 | Left port write strobe |
| l_addr | input | ADDR_W | Left port word address |
| r_ce | input | 1 | Right port enable |
| r_we | input | 1 | Right port write strobe |
| r_addr | input | ADDR_W | Right port word address |
| l_busy_in_n | input | 1 | External busy for the left port (slave mode) |
| r_busy_in_n | input | 1 | External busy for the right port (slave mode) |
| l_busy_n | output | 1 | Busy toward the left port, active low |
| r_busy_n | output | 1 | Busy toward the right port, active low |
| l_wr_ok | output | 1 | Left write may proceed |
| r_wr_ok | output | 1 | Right write may proceed |
| l_rd_unsure | output | 1 | Left read data not deterministic |
| r_rd_unsure | output | 1 | Right read data not deterministic |

## Verification
The bench builds the arbiter with ADDR_W=3, which makes the address space eight words. Every pair of left and right addresses can then be swept with every combination of write strobes, both for simultaneous arrival and for each port arriving first. These sweeps cover the tie rule, the first-arrival rule, the hold-until-release rule and the idle case. Directed sequences move the owner's address away and back so that the grant is handed over. Other sequences toggle the external busy inputs in slave mode to measure the sampling delay and the extra settle cycle.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
    typedef enum logic [1:0] {
        GR_FREE  = 2'd0,
        GR_LEFT  = 2'd1,
        GR_RIGHT = 2'd2
    } grant_e;
endpackage

// File: rtl/dpc_track.sv
module dpc_track #(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic [ADDR_W-1:0] addr,
    output logic              hold
);
    logic              ce_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ce_q   <= 1'b0;
            addr_q <= '0;
        end else begin
            ce_q   <= ce;
            addr_q <= addr;
        end
    end

    // an access continues when the port stays enabled on the same word
    always_comb hold = ce && ce_q && (addr == addr_q);
endmodule

// File: rtl/dpc_grant_fsm.sv
module dpc_grant_fsm
    import dpc_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_ce,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_hold,
    input  logic              r_ce,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_hold,
    output logic              l_blk,
    output logic              r_blk
);
    grant_e state, nxt, fresh;
    logic   match;

    always_comb begin
        match = l_ce && r_ce && (l_addr == r_addr);
        // a newcomer loses to a port already on the word; ties go left
        fresh = (r_hold && !l_hold) ? GR_RIGHT : GR_LEFT;
        unique case (state)
            GR_FREE:  nxt = match ? fresh : GR_FREE;
            GR_LEFT:  nxt = !match ? GR_FREE : (l_hold ? GR_LEFT : fresh);
            GR_RIGHT: nxt = !match ? GR_FREE : (r_hold ? GR_RIGHT : fresh);
            default:  nxt = GR_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= GR_FREE;
        else        state <= nxt;
    end

    always_comb begin
        l_blk = 1'b0;
        r_blk = 1'b0;
        unique case (nxt)
            GR_FREE:  ;
            GR_LEFT:  r_blk = 1'b1;
            GR_RIGHT: l_blk = 1'b1;
            default:  ;
        endcase
    end

    a_r2_one_loser: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> $countones({l_blk, r_blk}) == 1);
endmodule

// File: rtl/dpc_slave_gate.sv
module dpc_slave_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_in_n,
    output logic busy_s_n,
    output logic settling
);
    logic busy_d_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_s_n <= 1'b1;
            busy_d_n <= 1'b1;
        end else begin
            busy_s_n <= busy_in_n;
            busy_d_n <= busy_s_n;
        end
    end

    // one cycle of hold-off after the sampled busy changes
    always_comb settling = busy_s_n ^ busy_d_n;
endmodule

// File: rtl/dpc_arbiter.sv
module dpc_arbiter #(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_mode,
    input  logic              l_ce,
    input  logic              l_we,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              r_ce,
    input  logic              r_we,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              l_busy_in_n,
    input  logic              r_busy_in_n,
    output logic              l_busy_n,
    output logic              r_busy_n,
    output logic              l_wr_ok,
    output logic              r_wr_ok,
    output logic              l_rd_unsure,
    output logic              r_rd_unsure
);
    localparam int NPORT = 2;

    logic [NPORT-1:0]  ce_v, we_v, hold_v, bin_v, bs_v, set_v, blk_v, wok_v, unsure_v;
    logic [ADDR_W-1:0] addr_v [NPORT];

    always_comb begin
        ce_v      = {r_ce, l_ce};
        we_v      = {r_we, l_we};
        bin_v     = {r_busy_in_n, l_busy_in_n};
        addr_v[0] = l_addr;
        addr_v[1] = r_addr;
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        dpc_track #(.ADDR_W(ADDR_W)) u_track (
            .clk  (clk),
            .rst_n(rst_n),
            .ce   (ce_v[p]),
            .addr (addr_v[p]),
            .hold (hold_v[p])
        );
        dpc_slave_gate u_gate (
            .clk      (clk),
            .rst_n    (rst_n),
            .busy_in_n(bin_v[p]),
            .busy_s_n (bs_v[p]),
            .settling (set_v[p])
        );
        always_comb begin
            if (master_mode) begin
                wok_v[p]    = ce_v[p] && we_v[p] && !blk_v[p];
                unsure_v[p] = ce_v[p] && !we_v[p] && blk_v[p];
            end else begin
                wok_v[p]    = ce_v[p] && we_v[p] && bs_v[p] && !set_v[p];
                unsure_v[p] = ce_v[p] && !we_v[p] && !bs_v[p];
            end
        end
    end

    dpc_grant_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .l_ce  (l_ce),
        .l_addr(l_addr),
        .l_hold(hold_v[0]),
        .r_ce  (r_ce),
        .r_addr(r_addr),
        .r_hold(hold_v[1]),
        .l_blk (blk_v[0]),
        .r_blk (blk_v[1])
    );

    always_comb begin
        l_busy_n    = !(master_mode && blk_v[0]);
        r_busy_n    = !(master_mode && blk_v[1]);
        l_wr_ok     = wok_v[0];
        r_wr_ok     = wok_v[1];
        l_rd_unsure = unsure_v[0];
        r_rd_unsure = unsure_v[1];
    end

    a_r1_idle_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && !(l_ce && r_ce && l_addr == r_addr)) |-> (l_busy_n && r_busy_n));
    a_r3_owner_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && !r_busy_n && l_ce) |=>
        (!(master_mode && l_ce && r_ce && $stable(l_addr) && l_addr == r_addr) || !r_busy_n));
    a_r5_busy_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && (!l_busy_n || !r_busy_n)) |-> !(l_busy_n ? r_wr_ok : l_wr_ok));
    a_r7_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !master_mode |-> (l_busy_n && r_busy_n));
    a_r7_slave_block: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_mode && $past(!master_mode) && $past(!l_busy_in_n)) |-> !l_wr_ok);
    a_r8_settle: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_mode && $past(!master_mode) && $past(l_busy_in_n) && $past(!l_busy_in_n, 2))
        |-> !l_wr_ok);
endmodule

// File: tb/dpc_arbiter_test.sv
module dpc_arbiter_test;
    localparam int AW = 3;
    localparam int NA = 1 << AW;

    logic clk = 1'b0, rst_n = 1'b0, master_mode = 1'b1;
    logic l_ce = 0, l_we = 0, r_ce = 0, r_we = 0;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic l_busy_in_n = 1, r_busy_in_n = 1;
    logic l_busy_n, r_busy_n, l_wr_ok, r_wr_ok, l_rd_unsure, r_rd_unsure;
    int checks = 0, bad = 0;

    always #10 clk = ~clk;

    dpc_arbiter #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
        .l_ce(l_ce), .l_we(l_we), .l_addr(l_addr),
        .r_ce(r_ce), .r_we(r_we), .r_addr(r_addr),
        .l_busy_in_n(l_busy_in_n), .r_busy_in_n(r_busy_in_n),
        .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
        .l_wr_ok(l_wr_ok), .r_wr_ok(r_wr_ok),
        .l_rd_unsure(l_rd_unsure), .r_rd_unsure(r_rd_unsure));

    // expected {l_busy_n, r_busy_n, l_wr_ok, r_wr_ok, l_rd_unsure, r_rd_unsure}
    function automatic logic [5:0] expv(input logic lb, input logic rb);
        return {!lb, !rb, l_ce & l_we & !lb, r_ce & r_we & !rb,
                l_ce & !l_we & lb, r_ce & !r_we & rb};
    endfunction

    task automatic chk(input string req, input logic [5:0] exp);
        logic [5:0] act;
        act = {l_busy_n, r_busy_n, l_wr_ok, r_wr_ok, l_rd_unsure, r_rd_unsure};
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b (la=%0d ra=%0d)", req, act, exp, l_addr, r_addr);
        end
    endtask

    task automatic drive(input logic lc, input logic [AW-1:0] la, input logic lw,
                         input logic rc, input logic [AW-1:0] ra, input logic rw);
        @(negedge clk);
        l_ce = lc; l_addr = la; l_we = lw;
        r_ce = rc; r_addr = ra; r_we = rw;
        #2;
    endtask

    task automatic slave_step(input logic bin, input logic exp_ok, input string req);
        @(negedge clk);
        l_busy_in_n = bin;
        #2;
        checks++;
        if (l_wr_ok !== exp_ok || l_busy_n !== 1'b1 || r_busy_n !== 1'b1) begin
            bad++;
            $display("FAIL %s: wr_ok=%b busy=%b%b expected wr_ok=%b busy=11",
                     req, l_wr_ok, l_busy_n, r_busy_n, exp_ok);
        end
    endtask

    initial begin
        #3;
        chk("R9 reset", 6'b110000);
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #2 chk("R9 after reset", 6'b110000);

        // simultaneous arrival, every address pair and strobe combination
        for (int a = 0; a < NA; a++)
            for (int b = 0; b < NA; b++)
                for (int w = 0; w < 4; w++) begin
                    drive(0, 0, 0, 0, 0, 0);
                    drive(1, a[AW-1:0], w[0], 1, b[AW-1:0], w[1]);
                    chk(a == b ? "R2 tie left wins" : "R1 no match",
                        expv(1'b0, a == b));
                    drive(1, a[AW-1:0], w[0], 1, b[AW-1:0], w[1]);
                    chk("R4 tie held", expv(1'b0, a == b));
                    drive(0, a[AW-1:0], w[0], 1, b[AW-1:0], w[1]);
                    chk("R4 owner drops ce", expv(1'b0, 1'b0));
                end

        // one port first, then the other arrives
        for (int a = 0; a < NA; a++)
            for (int b = 0; b < NA; b++) begin
                drive(0, 0, 0, 0, 0, 0);
                drive(1, a[AW-1:0], 1, 0, b[AW-1:0], 1);
                chk("R1 single port", expv(1'b0, 1'b0));
                drive(1, a[AW-1:0], 1, 1, b[AW-1:0], 1);
                chk("R3 right late", expv(1'b0, a == b));
                drive(0, 0, 0, 0, 0, 0);
                drive(0, a[AW-1:0], 0, 1, b[AW-1:0], 0);
                drive(1, a[AW-1:0], 0, 1, b[AW-1:0], 0);
                chk("R3 left late", expv(a == b, 1'b0));
                drive(1, a[AW-1:0], 1, 1, b[AW-1:0], 1);
                chk("R5 R6 left late held", expv(a == b, 1'b0));
            end

        // handover: right owns, moves away, comes back as newcomer
        drive(0, 0, 0, 0, 0, 0);
        drive(0, 5, 1, 1, 5, 1);
        drive(1, 5, 1, 1, 5, 1);
        chk("R3 right owns", expv(1'b1, 1'b0));
        drive(1, 5, 1, 1, 6, 1);
        chk("R4 owner moved", expv(1'b0, 1'b0));
        drive(1, 5, 1, 1, 5, 1);
        chk("R4 left now holder", expv(1'b0, 1'b1));
        drive(1, 5, 0, 1, 5, 0);
        chk("R6 right read flagged", expv(1'b0, 1'b1));

        // slave mode
        drive(0, 0, 0, 0, 0, 0);
        master_mode = 1'b0;
        drive(1, 2, 1, 1, 2, 1);
        chk("R7 slave ignores match", 6'b111100);
        slave_step(1'b0, 1'b1, "R7 busy not yet sampled");
        slave_step(1'b0, 1'b0, "R7 sampled busy blocks");
        slave_step(1'b1, 1'b0, "R7 release not yet sampled");
        slave_step(1'b1, 1'b0, "R8 settle cycle");
        slave_step(1'b1, 1'b1, "R8 write allowed again");
        slave_step(1'b0, 1'b1, "R7 second busy pending");
        drive(1, 2, 0, 1, 2, 1);
        checks++;
        if (l_rd_unsure !== 1'b1 || r_wr_ok !== 1'b1) begin
            bad++;
            $display("FAIL R7 slave read flag: unsure=%b r_wr_ok=%b expected 1 1",
                     l_rd_unsure, r_wr_ok);
        end

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        bad++;
        checks++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule